// File: doc/BRIEF.md
# Virtual Address Translator with TLB and Page-Table Walk

This block turns a virtual address into a physical address. A small fully associative translation cache sits in front of a single-level page table, and both live in registers inside the block. Each accepted reference ends with a single-cycle `done` pulse. The pulse carries the physical address and one of three outcome codes: the cache held the page, the page table held it, or the page was missing and had to be allocated.

A miss in the translation cache reads the page table in a fixed extra cycle. When the table entry is absent, the block resolves the fault itself in one more cycle. It gives the page a fresh physical page number, one above the largest page number handed out so far, and marks the table entry valid. After either kind of miss, the translation is copied into the cache. The copy goes to the lowest-numbered empty slot, or, when all slots are full, to the least recently used one.

A preset port writes single cache or table entries while the block is idle. This lets a starting state be installed before traffic begins.

Top module: `vm_translator`

## Requirements
- R1: The low 12 bits of `pa` equal the low 12 bits of the requested virtual address, and the bits above them are the translated physical page number.
- R2: A request whose virtual page matches a valid cache entry produces `done` one cycle after it is presented, with `res` = 0 and that entry's page number.
- R3: A cache miss whose page-table entry is valid produces `done` two cycles after the request, with `res` = 1 and the table's page number, and the translation is then cached so the next reference to that page is a cache hit.
- R4: A cache miss whose table entry is invalid produces `done` three cycles after the request, with `res` = 2 and page number one above the largest valid page number written since reset. The table entry becomes valid with that number, so a later reference after cache eviction is a table hit with the same number.
- R5: A refill uses the lowest-indexed invalid cache entry whenever one exists.
- R6: With every cache entry valid, a refill replaces the least recently referenced entry. After reset, entry j is treated as having been referenced j steps ago.
- R7: `busy` is high while a miss is being resolved, and a request presented while `busy` is high is ignored.
- R8: Every accepted request yields exactly one `done` pulse, and `res` is never 3.
- R9: With `ld_en` high while idle, `ld_tlb` = 1 writes cache entry `ld_idx[1:0]` (valid, tag `ld_vpn`, page `ld_ppn`), and `ld_tlb` = 0 writes table entry `ld_idx` (valid, page `ld_ppn`). Each valid write raises the largest-allocated mark when `ld_ppn` exceeds it.
- R10: After reset `done` and `busy` are low and every cache and table entry is invalid, so the first reference faults with page number 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_va | input | 16 | Virtual address |
| ld_en | input | 1 | Preset write strobe, taken when idle |
| ld_tlb | input | 1 | 1 selects a cache entry, 0 a table entry |
| ld_idx | input | 4 | Entry index |
| ld_valid | input | 1 | Valid bit to write |
| ld_vpn | input | 4 | Tag for a cache entry |
| ld_ppn | input | 8 | Physical page number to write |
| busy | output | 1 | Miss in progress |
| done | output | 1 | One-cycle completion pulse |
| res | output | 2 | Outcome: 0 cache hit, 1 table hit, 2 fault |
| pa | output | 20 | Physical address |

## Verification
The bench builds the block with its defaults: a 16-bit virtual address (sixteen pages), four cache entries and 8-bit page numbers. At these values the whole table can be preset in a few cycles. A short reference stream then fills the cache, forces replacement by age, faults several pages and later walks back to them. Each fault page number can be predicted from the preset mark.

// File: rtl/vmt_pkg.sv
package vmt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WALK  = 2'd1,
        ST_ALLOC = 2'd2
    } walk_state_e;

    typedef enum logic [1:0] {
        RES_TLB   = 2'd0,
        RES_TABLE = 2'd1,
        RES_FAULT = 2'd2
    } outcome_e;
endpackage

// File: rtl/vmt_tlb_cam.sv
module vmt_tlb_cam #(
    parameter int N      = 4,
    parameter int VPN_W  = 4,
    parameter int IDX_W  = 2
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]        key,
    output logic                    hit,
    output logic [IDX_W-1:0]        hit_idx
);
    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int j = N - 1; j >= 0; j--) begin
            if (match[j]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/vmt_refill_pick.sv
module vmt_refill_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][IDX_W-1:0] age,
    output logic [IDX_W-1:0]        slot
);
    logic               have_free;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   old_idx;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        old_idx   = '0;
        for (int j = N - 1; j >= 0; j--) begin
            if (!valid[j]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(j);
            end
            if (age[j] == IDX_W'(N - 1)) begin
                old_idx = IDX_W'(j);
            end
        end
        slot = have_free ? free_idx : old_idx;
    end
endmodule

// File: rtl/vm_translator.sv
module vm_translator #(
    parameter int VA_W   = 16,
    parameter int OFF_W  = 12,
    parameter int PPN_W  = 8,
    parameter int TLB_N  = 4,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PA_W  = PPN_W + OFF_W,
    localparam int PT_N  = 1 << VPN_W,
    localparam int TIDX_W = (TLB_N > 1) ? $clog2(TLB_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic              ld_en,
    input  logic              ld_tlb,
    input  logic [VPN_W-1:0]  ld_idx,
    input  logic              ld_valid,
    input  logic [VPN_W-1:0]  ld_vpn,
    input  logic [PPN_W-1:0]  ld_ppn,
    output logic              busy,
    output logic              done,
    output logic [1:0]        res,
    output logic [PA_W-1:0]   pa
);
    import vmt_pkg::*;

    typedef logic [TLB_N-1:0][TIDX_W-1:0] ages_t;

    typedef struct packed {
        walk_state_e                   st;
        logic [TLB_N-1:0]              tv;
        logic [TLB_N-1:0][VPN_W-1:0]   ttag;
        logic [TLB_N-1:0][PPN_W-1:0]   tppn;
        ages_t                         age;
        logic [PT_N-1:0]               pv;
        logic [PT_N-1:0][PPN_W-1:0]    pppn;
        logic [PPN_W-1:0]              maxp;
        logic [VPN_W-1:0]              vpn;
        logic [OFF_W-1:0]              off;
        logic                          done;
        outcome_e                      res;
        logic [PA_W-1:0]               pa;
    } regs_t;

    regs_t r_q, r_d;

    logic                cam_hit;
    logic [TIDX_W-1:0]   cam_idx;
    logic [TIDX_W-1:0]   fill_slot;
    logic [TLB_N*TIDX_W-1:0] age_view;

    vmt_tlb_cam #(.N(TLB_N), .VPN_W(VPN_W), .IDX_W(TIDX_W)) u_cam (
        .valid   (r_q.tv),
        .tags    (r_q.ttag),
        .key     (req_va[VA_W-1:OFF_W]),
        .hit     (cam_hit),
        .hit_idx (cam_idx)
    );

    vmt_refill_pick #(.N(TLB_N), .IDX_W(TIDX_W)) u_pick (
        .valid (r_q.tv),
        .age   (r_q.age),
        .slot  (fill_slot)
    );

    function automatic ages_t touch(input ages_t a, input logic [TIDX_W-1:0] k);
        ages_t n = a;
        for (int j = 0; j < TLB_N; j++) begin
            if (a[j] < a[k]) n[j] = a[j] + 1'b1;
        end
        n[k] = '0;
        return n;
    endfunction

    always_comb begin
        logic [PPN_W-1:0] new_ppn;
        r_d      = r_q;
        r_d.done = 1'b0;
        new_ppn  = r_q.maxp + 1'b1;
        unique case (r_q.st)
            ST_IDLE: begin
                if (ld_en) begin
                    if (ld_tlb) begin
                        r_d.tv[ld_idx[TIDX_W-1:0]]   = ld_valid;
                        r_d.ttag[ld_idx[TIDX_W-1:0]] = ld_vpn;
                        r_d.tppn[ld_idx[TIDX_W-1:0]] = ld_ppn;
                    end else begin
                        r_d.pv[ld_idx]   = ld_valid;
                        r_d.pppn[ld_idx] = ld_ppn;
                    end
                    if (ld_valid && (ld_ppn > r_q.maxp)) r_d.maxp = ld_ppn;
                end else if (req_valid) begin
                    r_d.vpn = req_va[VA_W-1:OFF_W];
                    r_d.off = req_va[OFF_W-1:0];
                    if (cam_hit) begin
                        r_d.done = 1'b1;
                        r_d.res  = RES_TLB;
                        r_d.pa   = {r_q.tppn[cam_idx], req_va[OFF_W-1:0]};
                        r_d.age  = touch(r_q.age, cam_idx);
                    end else begin
                        r_d.st = ST_WALK;
                    end
                end
            end
            ST_WALK: begin
                if (r_q.pv[r_q.vpn]) begin
                    r_d.tv[fill_slot]   = 1'b1;
                    r_d.ttag[fill_slot] = r_q.vpn;
                    r_d.tppn[fill_slot] = r_q.pppn[r_q.vpn];
                    r_d.age  = touch(r_q.age, fill_slot);
                    r_d.done = 1'b1;
                    r_d.res  = RES_TABLE;
                    r_d.pa   = {r_q.pppn[r_q.vpn], r_q.off};
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.st = ST_ALLOC;
                end
            end
            ST_ALLOC: begin
                r_d.pv[r_q.vpn]     = 1'b1;
                r_d.pppn[r_q.vpn]   = new_ppn;
                r_d.maxp            = new_ppn;
                r_d.tv[fill_slot]   = 1'b1;
                r_d.ttag[fill_slot] = r_q.vpn;
                r_d.tppn[fill_slot] = new_ppn;
                r_d.age  = touch(r_q.age, fill_slot);
                r_d.done = 1'b1;
                r_d.res  = RES_FAULT;
                r_d.pa   = {new_ppn, r_q.off};
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.res  <= RES_TLB;
            for (int j = 0; j < TLB_N; j++) begin
                r_q.age[j] <= TIDX_W'(j);
            end
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign done     = r_q.done;
    assign res      = r_q.res;
    assign pa       = r_q.pa;
    assign age_view = r_q.age;
endmodule

// File: rtl/vmt_checker.sv
module vmt_checker #(
    parameter int N     = 4,
    parameter int IDX_W = 2,
    parameter int VA_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              ld_en,
    input logic [VA_W-1:0]   req_va,
    input logic              busy,
    input logic              done,
    input logic [1:0]        res,
    input logic [N*IDX_W-1:0] age_view
);
    logic [N-1:0] seen;

    always_comb begin
        seen = '0;
        for (int j = 0; j < N; j++) begin
            seen[age_view[j*IDX_W +: IDX_W]] = 1'b1;
        end
    end

    // R8: outcome code 3 is never reported
    a_r8_res_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res != 2'd3));

    // R7: no completion while a miss is still being resolved
    a_r7_busy_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R2: an accepted request either hits next cycle or starts a walk
    a_r2_hit_or_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !ld_en) |=> (done || busy));

    // R3: a finished walk always reports a completion
    a_r3_walk_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R6: the ages always form a permutation of 0..N-1
    a_r6_age_permutation: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen) == N);

    // R1: request address is stable-independent; keep address bus known when used
    a_r1_va_known: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |-> !$isunknown(req_va));
endmodule

bind vm_translator vmt_checker #(.N(TLB_N), .IDX_W(TIDX_W), .VA_W(VA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ld_en     (ld_en),
    .req_va    (req_va),
    .busy      (busy),
    .done      (done),
    .res       (res),
    .age_view  (age_view)
);

// File: tb/tb_vm_translator.sv
module tb_vm_translator;
    localparam int VA_W = 16, OFF_W = 12, PPN_W = 8, TN = 4;
    localparam int VPN_W = VA_W - OFF_W, PT_N = 1 << VPN_W, PA_W = PPN_W + OFF_W;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, ld_en = 0, ld_tlb = 0, ld_valid = 0;
    logic [VA_W-1:0] req_va = '0;
    logic [VPN_W-1:0] ld_idx = '0, ld_vpn = '0;
    logic [PPN_W-1:0] ld_ppn = '0;
    logic busy, done;
    logic [1:0] res;
    logic [PA_W-1:0] pa;

    always #5 clk = ~clk;

    vm_translator dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .ld_en(ld_en), .ld_tlb(ld_tlb), .ld_idx(ld_idx), .ld_valid(ld_valid),
        .ld_vpn(ld_vpn), .ld_ppn(ld_ppn),
        .busy(busy), .done(done), .res(res), .pa(pa)
    );

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // reference model
    bit mtv[TN];
    int mtag[TN], mppn[TN], mage[TN];
    bit mpv[PT_N];
    int mppt[PT_N];
    int mmax;

    // scoreboard queues
    int    q_res[$], q_pa[$], q_cyc[$];
    string q_tag[$];

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic m_touch(input int k);
        int a = mage[k];
        for (int j = 0; j < TN; j++) if (mage[j] < a) mage[j]++;
        mage[k] = 0;
    endtask

    task automatic predict(input int va, output int r, output int p, output int lat);
        int vpn = va >> OFF_W;
        int off = va & ((1 << OFF_W) - 1);
        int hit = -1, slot = -1, ppn;
        for (int j = TN - 1; j >= 0; j--) if (mtv[j] && mtag[j] == vpn) hit = j;
        if (hit >= 0) begin
            m_touch(hit);
            r = 0; lat = 1; ppn = mppn[hit];
        end else begin
            for (int j = TN - 1; j >= 0; j--) if (!mtv[j]) slot = j;
            if (slot < 0) for (int j = 0; j < TN; j++) if (mage[j] == TN - 1) slot = j;
            if (mpv[vpn]) begin
                r = 1; lat = 2; ppn = mppt[vpn];
            end else begin
                mmax = (mmax + 1) % (1 << PPN_W);
                r = 2; lat = 3; ppn = mmax;
                mpv[vpn] = 1; mppt[vpn] = ppn;
            end
            mtv[slot] = 1; mtag[slot] = vpn; mppn[slot] = ppn;
            m_touch(slot);
        end
        p = (ppn << OFF_W) | off;
    endtask

    task automatic issue(input int va, input string tag, input bit intrude = 0, input int other = 0);
        int r, p, lat;
        predict(va, r, p, lat);
        q_res.push_back(r); q_pa.push_back(p); q_cyc.push_back(cyc + lat); q_tag.push_back(tag);
        req_valid = 1; req_va = VA_W'(va);
        @(negedge clk);
        req_valid = 0;
        if (intrude && lat >= 2) begin
            chk(busy === 1'b1, "R7", "busy during walk", busy, 1);
            req_valid = 1; req_va = VA_W'(other);
            @(negedge clk);
            req_valid = 0;
            repeat (lat - 2) @(negedge clk);
        end else begin
            repeat (lat - 1) @(negedge clk);
        end
    endtask

    task automatic load(input bit tlb, input int idx, input bit v, input int vpn, input int ppn);
        ld_en = 1; ld_tlb = tlb; ld_idx = VPN_W'(idx); ld_valid = v;
        ld_vpn = VPN_W'(vpn); ld_ppn = PPN_W'(ppn);
        @(negedge clk);
        ld_en = 0;
        if (tlb) begin mtv[idx] = v; mtag[idx] = vpn; mppn[idx] = ppn; end
        else begin mpv[idx] = v; mppt[idx] = ppn; end
        if (v && ppn > mmax) mmax = ppn;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q_res.size() == 0) begin
                chk(0, "R8", "unexpected done", 1, 0);
            end else begin
                int er, ep, ec;
                string t;
                er = q_res.pop_front(); ep = q_pa.pop_front();
                ec = q_cyc.pop_front(); t = q_tag.pop_front();
                chk(res == 2'(er), t, "outcome (R2/R3/R4)", res, er);
                chk(pa == PA_W'(ep), t, "physical address (R1)", pa, ep);
                chk(cyc == ec, t, "completion cycle", cyc, ec);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        finish_run();
    end

    initial begin
        for (int j = 0; j < TN; j++) begin mtv[j] = 0; mtag[j] = 0; mppn[j] = 0; mage[j] = j; end
        for (int j = 0; j < PT_N; j++) begin mpv[j] = 0; mppt[j] = 0; end
        mmax = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(done === 1'b0, "R10", "done after reset", done, 0);
        chk(busy === 1'b0, "R10", "busy after reset", busy, 0);
        issue('hF123, "R10");               // empty system: fault with page 1

        // preset state (R9)
        load(1, 0, 1, 11, 12);
        load(1, 1, 1, 7, 4);
        load(1, 2, 1, 3, 6);
        load(1, 3, 0, 4, 9);
        load(0, 0, 1, 0, 5);
        load(0, 3, 1, 0, 6);
        load(0, 4, 1, 0, 9);
        load(0, 5, 1, 0, 11);
        load(0, 7, 1, 0, 4);
        load(0, 10, 1, 0, 3);
        load(0, 11, 1, 0, 12);

        issue(31272, "R9");                 // preset cache entry hit
        issue(4095,  "R3");                 // table hit, fills free entry 3
        issue(4095 - 100, "R5");            // same page now cached
        issue(15789, "R2");
        issue(15000, "R1");
        issue(7193,  "R4");                 // fault: page 13
        issue(4096,  "R2");
        issue(8912,  "R6");                 // fault: page 14, evicts oldest
        issue('hB0AB, "R6");                // page 11 was preset in cache tag 11?
        issue('h5ABC, "R7", 1, 'hA000);     // intruding request ignored
        issue('hA001, "R7");
        issue('h6010, "R4");
        issue('h8020, "R4");
        issue('h9030, "R4");
        issue('h1FFF, "R4");                // faulted page walked again
        issue('h1000, "R2");
        issue('h2ABC, "R6");
        @(negedge clk);
        @(negedge clk);
        chk(q_res.size() == 0, "R8", "pending completions", q_res.size(), 0);
        finish_run();
    end
endmodule